// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the tail end of an I2C master. After a byte has been received it drives the acknowledge bit on the bus. At the end of a transfer it produces the Stop condition. Software-style control comes in as two single-cycle requests, one for acknowledge and one for Stop, plus the value of the acknowledge bit. Each bus line is driven by an active-high pull-low enable, so the lines are open-drain. Both lines are read back through a two-flop synchronizer. Because the block waits for the clock line to actually read high, a slave can stretch the clock.

Every timed phase is measured by a down-counter that reloads from a programmable value. One phase lasts (reload + 1) clocks. A phase that follows a line change starts counting only once the synchronized line shows the expected level. The block also holds the transmit data register. A write to that register while a sequence is running is refused and raises a sticky collision flag.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After a synchronous reset both pull-low enables are 0, and busy, ack_done, stop_seen, irq and wcol are all 0. txbuf_q is 0x00.
- R2: An ack_go pulse while idle sets scl_drv_low to 1 and busy to 1 on the next cycle. On the same cycle sda_drv_low becomes the inverse of ack_bit, so ack_bit 0 gives ACK (SDA pulled low) and ack_bit 1 gives NACK (SDA released). A new acknowledge clears ack_done.
- R3: During an acknowledge, SCL stays pulled low for reload+1 cycles and is then released. The high-phase count of reload+1 cycles starts only once the synchronized SCL reads 1, so a slave that holds SCL low lengthens the released time.
- R4: When the acknowledge high phase expires, SCL is pulled low again and the block returns to idle. At the same time ack_done is set and irq pulses high for exactly one cycle.
- R5: A stop_go pulse while idle pulls both SCL and SDA low on the next cycle. Counting starts only once the synchronized SDA reads 0. SCL is released reload+1 cycles later, and SDA is released a further reload+1 cycles after that.
- R6: stop_seen is set once both synchronized lines read 1. reload+1 cycles after that the block goes idle and irq pulses for one cycle. A new Stop clears stop_seen.
- R7: A txbuf_wr while busy sets wcol and leaves txbuf_q unchanged. A txbuf_wr while idle loads txbuf_wdata into txbuf_q. wcol_clr clears wcol, but a colliding write in the same cycle wins.
- R8: If ack_go and stop_go arrive in the same idle cycle, the acknowledge runs first and the Stop starts on the first cycle after it ends. busy stays 1 in between. Any ack_go or stop_go that arrives while busy is ignored.
- R9: scl_in and sda_in pass through two synchronizer flops. With a slave stretch of N cycles, the acknowledge SCL released time is N + reload + 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_go | input | 1 | Request an acknowledge sequence (pulse) |
| stop_go | input | 1 | Request a Stop sequence (pulse) |
| ack_bit | input | 1 | Acknowledge value: 0 gives ACK, 1 gives NACK |
| reload | input | CW | Phase counter reload value; a phase lasts reload+1 clocks |
| scl_in | input | 1 | Clock line as read from the bus |
| sda_in | input | 1 | Data line as read from the bus |
| txbuf_wr | input | 1 | Write strobe for the transmit data register |
| txbuf_wdata | input | DW | Data for the transmit data register |
| wcol_clr | input | 1 | Clears the collision flag |
| scl_drv_low | output | 1 | 1 pulls the clock line low |
| sda_drv_low | output | 1 | 1 pulls the data line low |
| busy | output | 1 | A sequence is running or queued |
| ack_done | output | 1 | Last acknowledge sequence finished |
| stop_seen | output | 1 | Stop condition observed on the bus |
| irq | output | 1 | One-cycle pulse at the end of a sequence |
| wcol | output | 1 | Sticky write-collision flag |
| txbuf_q | output | DW | Transmit data register contents |

## Verification
The bench models a slave that holds SCL low for a set number of cycles after release. It checks that the acknowledge high time is counted only once SCL is seen high. A design that counted from the release instead would shorten the released time by the stretch length. Simultaneous acknowledge and Stop requests are checked for ordering: a design that dropped the queued Stop, or let a write slip in between the two sequences, would differ in busy and stop_seen. The bench also writes the data register during both sequences and during idle, to catch a refused write that still changes the data or a legal write that raises wcol. Both acknowledge polarities and a reload of zero are covered, because an off-by-one in the counter shows up most clearly with a one-cycle phase.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ACK_LOW,
        SQ_ACK_WAIT,
        SQ_ACK_HIGH,
        SQ_STP_SDA,
        SQ_STP_SCL,
        SQ_STP_REL,
        SQ_STP_WAIT,
        SQ_STP_FIN
    } seq_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    function automatic logic in_stop(seq_state_e s);
        return (s == SQ_STP_SDA) || (s == SQ_STP_SCL) || (s == SQ_STP_REL) ||
               (s == SQ_STP_WAIT) || (s == SQ_STP_FIN);
    endfunction

endpackage

// File: rtl/i2c_as_sync.sv
module i2c_as_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '1;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= '1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_as_timer.sv
module i2c_as_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] reload,
    output logic          tick
);
    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= reload;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    p_load_value_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> run && (cnt == $past(reload)));
    p_tick_ends_run_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> !run);
endmodule

// File: rtl/i2c_as_txbuf.sv
module i2c_as_txbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          clr,
    output logic [DW-1:0] q,
    output logic          wcol
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            wcol <= 1'b0;
        end else begin
            if (wr && busy)  wcol <= 1'b1;
            else if (clr)    wcol <= 1'b0;
            if (wr && !busy) q <= wdata;
        end
    end

    p_wcol_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && busy) |=> wcol && $stable(q));
endmodule

// File: rtl/i2c_as_fsm.sv
module i2c_as_fsm
    import i2c_as_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_go,
    input  logic       stop_go,
    input  logic       ack_bit,
    input  line_pair_t lines_s,
    input  logic       tick,
    output logic       cnt_load,
    output logic       scl_drv_low,
    output logic       sda_drv_low,
    output logic       busy,
    output logic       ack_done,
    output logic       stop_seen,
    output logic       irq
);
    seq_state_e state;
    logic       stop_pend;
    logic       go_ack, go_stop;

    always_comb begin
        go_ack  = (state == SQ_IDLE) && !stop_pend && ack_go;
        go_stop = (state == SQ_IDLE) && (stop_pend || (!ack_go && stop_go));
        unique case (state)
            SQ_IDLE:     cnt_load = go_ack;
            SQ_ACK_WAIT: cnt_load = lines_s.scl;
            SQ_STP_SDA:  cnt_load = !lines_s.sda;
            SQ_STP_SCL:  cnt_load = tick;
            SQ_STP_WAIT: cnt_load = lines_s.scl && lines_s.sda;
            default:     cnt_load = 1'b0;
        endcase
    end

    assign busy = (state != SQ_IDLE) || stop_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            stop_pend   <= 1'b0;
            scl_drv_low <= 1'b0;
            sda_drv_low <= 1'b0;
            ack_done    <= 1'b0;
            stop_seen   <= 1'b0;
            irq         <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (go_ack) begin
                        state       <= SQ_ACK_LOW;
                        scl_drv_low <= 1'b1;
                        sda_drv_low <= !ack_bit;
                        ack_done    <= 1'b0;
                        stop_pend   <= stop_go;
                    end else if (go_stop) begin
                        state       <= SQ_STP_SDA;
                        scl_drv_low <= 1'b1;
                        sda_drv_low <= 1'b1;
                        stop_seen   <= 1'b0;
                        stop_pend   <= 1'b0;
                    end
                end
                SQ_ACK_LOW: if (tick) begin
                    scl_drv_low <= 1'b0;
                    state       <= SQ_ACK_WAIT;
                end
                SQ_ACK_WAIT: if (lines_s.scl) state <= SQ_ACK_HIGH;
                SQ_ACK_HIGH: if (tick) begin
                    scl_drv_low <= 1'b1;
                    ack_done    <= 1'b1;
                    irq         <= 1'b1;
                    state       <= SQ_IDLE;
                end
                SQ_STP_SDA: if (!lines_s.sda) state <= SQ_STP_SCL;
                SQ_STP_SCL: if (tick) begin
                    scl_drv_low <= 1'b0;
                    state       <= SQ_STP_REL;
                end
                SQ_STP_REL: if (tick) begin
                    sda_drv_low <= 1'b0;
                    state       <= SQ_STP_WAIT;
                end
                SQ_STP_WAIT: if (lines_s.scl && lines_s.sda) begin
                    stop_seen <= 1'b1;
                    state     <= SQ_STP_FIN;
                end
                SQ_STP_FIN: if (tick) begin
                    irq   <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    p_ack_entry_r2: assert property (@(posedge clk) disable iff (rst)
        go_ack |=> scl_drv_low && (sda_drv_low == !$past(ack_bit)) && busy);
    p_high_waits_sync_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_ACK_WAIT && !lines_s.scl) |=> (state == SQ_ACK_WAIT) && !scl_drv_low);
    p_ack_end_r4: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_ACK_HIGH && tick) |=> scl_drv_low && irq && ack_done);
    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    p_stop_entry_r5: assert property (@(posedge clk) disable iff (rst)
        go_stop |=> scl_drv_low && sda_drv_low && in_stop(state));
    p_sda_after_scl_r5: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STP_REL && tick) |=> !sda_drv_low && !scl_drv_low);
    p_stop_seen_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_seen) |-> $past(lines_s.scl && lines_s.sda));
    p_pend_order_r8: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && stop_pend) |=> (state == SQ_STP_SDA));
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
    import i2c_as_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack_go,
    input  logic          stop_go,
    input  logic          ack_bit,
    input  logic [CW-1:0] reload,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          txbuf_wr,
    input  logic [DW-1:0] txbuf_wdata,
    input  logic          wcol_clr,
    output logic          scl_drv_low,
    output logic          sda_drv_low,
    output logic          busy,
    output logic          ack_done,
    output logic          stop_seen,
    output logic          irq,
    output logic          wcol,
    output logic [DW-1:0] txbuf_q
);
    localparam int LW = $bits(line_pair_t);

    line_pair_t lines_s;
    logic [LW-1:0] lines_raw, lines_q;
    logic          tick, cnt_load;

    assign lines_raw = {scl_in, sda_in};
    assign lines_s   = line_pair_t'(lines_q);

    i2c_as_sync #(.W(LW), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .d (lines_raw), .q (lines_q)
    );

    i2c_as_timer #(.CW(CW)) u_timer (
        .clk (clk), .rst (rst), .load (cnt_load), .reload (reload), .tick (tick)
    );

    i2c_as_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ack_go      (ack_go),
        .stop_go     (stop_go),
        .ack_bit     (ack_bit),
        .lines_s     (lines_s),
        .tick        (tick),
        .cnt_load    (cnt_load),
        .scl_drv_low (scl_drv_low),
        .sda_drv_low (sda_drv_low),
        .busy        (busy),
        .ack_done    (ack_done),
        .stop_seen   (stop_seen),
        .irq         (irq)
    );

    i2c_as_txbuf #(.DW(DW)) u_txbuf (
        .clk   (clk),
        .rst   (rst),
        .busy  (busy),
        .wr    (txbuf_wr),
        .wdata (txbuf_wdata),
        .clr   (wcol_clr),
        .q     (txbuf_q),
        .wcol  (wcol)
    );
endmodule

// File: tb/i2c_ackstop_seq_bench.sv
module i2c_ackstop_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ack_go = 0, stop_go = 0, ack_bit = 0, txbuf_wr = 0, wcol_clr = 0;
    logic [7:0] reload = 8'd3, txbuf_wdata = 8'h00;
    logic       scl_drv_low, sda_drv_low, busy, ack_done, stop_seen, irq, wcol;
    logic [7:0] txbuf_q;
    logic       scl_line, sda_line;
    int         stretch = 0;
    int         nchk = 0, nfail = 0, cyc = 0;

    always #2 clk = ~clk;

    assign scl_line = !(scl_drv_low || (stretch > 0));
    assign sda_line = !sda_drv_low;

    i2c_ackstop_seq u_i2c_ackstop_seq (
        .clk(clk), .rst(rst), .ack_go(ack_go), .stop_go(stop_go), .ack_bit(ack_bit),
        .reload(reload), .scl_in(scl_line), .sda_in(sda_line), .txbuf_wr(txbuf_wr),
        .txbuf_wdata(txbuf_wdata), .wcol_clr(wcol_clr), .scl_drv_low(scl_drv_low),
        .sda_drv_low(sda_drv_low), .busy(busy), .ack_done(ack_done), .stop_seen(stop_seen),
        .irq(irq), .wcol(wcol), .txbuf_q(txbuf_q)
    );

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // values captured mid-cycle, used by the reference model at the next edge
    bit c_rst = 1, c_ack, c_stop, c_bit, c_wr, c_clr, c_scl = 1, c_sda = 1, c_sdrv;
    int c_reload;
    logic [7:0] c_data;

    // reference model state
    int  edge_no = 0, phase = 0, deadline = 0;
    bit  live = 0, pend = 0;
    bit  e_scl, e_sda, e_ackd, e_stps, e_irq, e_wcol;
    logic [7:0] e_tx;
    bit  s1c = 1, s2c = 1, s1d = 1, s2d = 1;

    always @(posedge clk) begin
        if (!c_sdrv && stretch > 0) stretch <= stretch - 1;
    end

    always @(posedge clk) begin
        bit was_busy;
        edge_no++;
        if (c_rst) begin
            live = 0; phase = 0; pend = 0;
            e_scl = 0; e_sda = 0; e_ackd = 0; e_stps = 0; e_irq = 0; e_wcol = 0;
            e_tx = 8'h00; s1c = 1; s2c = 1; s1d = 1; s2d = 1;
        end else begin
            live = 1;
            was_busy = (phase != 0) || pend;
            e_irq = 0;
            case (phase)
                0: begin
                    if (pend) begin
                        pend = 0; e_scl = 1; e_sda = 1; e_stps = 0; phase = 4;
                    end else if (c_ack) begin
                        e_scl = 1; e_sda = !c_bit; e_ackd = 0; phase = 1;
                        pend = c_stop; deadline = edge_no + c_reload + 1;
                    end else if (c_stop) begin
                        e_scl = 1; e_sda = 1; e_stps = 0; phase = 4;
                    end
                end
                1: if (edge_no == deadline) begin e_scl = 0; phase = 2; end
                2: if (s2c) begin deadline = edge_no + c_reload + 1; phase = 3; end
                3: if (edge_no == deadline) begin
                       e_scl = 1; e_ackd = 1; e_irq = 1; phase = 0;
                   end
                4: if (!s2d) begin deadline = edge_no + c_reload + 1; phase = 5; end
                5: if (edge_no == deadline) begin
                       e_scl = 0; deadline = edge_no + c_reload + 1; phase = 6;
                   end
                6: if (edge_no == deadline) begin e_sda = 0; phase = 7; end
                7: if (s2c && s2d) begin
                       e_stps = 1; deadline = edge_no + c_reload + 1; phase = 8;
                   end
                8: if (edge_no == deadline) begin e_irq = 1; phase = 0; end
                default: phase = 0;
            endcase
            if (c_wr && was_busy) e_wcol = 1;
            else if (c_clr) e_wcol = 0;
            if (c_wr && !was_busy) e_tx = c_data;
            s2c = s1c; s1c = c_scl;
            s2d = s1d; s1d = c_sda;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk("R3", "scl_drv_low", scl_drv_low, e_scl);
            chk("R5", "sda_drv_low", sda_drv_low, e_sda);
            chk("R8", "busy", busy, (phase != 0) || pend);
            chk("R4", "ack_done", ack_done, e_ackd);
            chk("R4", "irq", irq, e_irq);
            chk("R6", "stop_seen", stop_seen, e_stps);
            chk("R7", "wcol", wcol, e_wcol);
            chk("R7", "txbuf_q", txbuf_q, e_tx);
        end
        c_rst = rst; c_ack = ack_go; c_stop = stop_go; c_bit = ack_bit;
        c_wr = txbuf_wr; c_clr = wcol_clr; c_data = txbuf_wdata; c_reload = reload;
        c_scl = scl_line; c_sda = sda_line; c_sdrv = scl_drv_low;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) step();
        step(); step();
    endtask

    task automatic start_ack(bit b);
        ack_bit = b; ack_go = 1; step(); ack_go = 0;
    endtask

    task automatic start_stop();
        stop_go = 1; step(); stop_go = 0;
    endtask

    task automatic ack_timed(bit b, int r, int n);
        int lo, hi;
        reload = 8'(r); stretch = n;
        start_ack(b);
        chk("R2", "scl pulled low on entry", scl_drv_low, 1);
        chk("R2", "sda reflects ack_bit", sda_drv_low, !b);
        chk("R2", "busy on entry", busy, 1);
        lo = 0; hi = 0;
        while (scl_drv_low && lo < 1000) begin step(); lo++; end
        chk("R3", "scl low cycles", lo, r + 1);
        while (!scl_drv_low && hi < 1000) begin step(); hi++; end
        chk("R9", "scl released cycles incl stretch", hi, n + r + 4);
        wait_idle();
        chk("R4", "ack_done after ack", ack_done, 1);
    endtask

    task automatic stop_timed(int r);
        int gap;
        reload = 8'(r);
        start_stop();
        chk("R5", "stop pulls scl low", scl_drv_low, 1);
        chk("R5", "stop pulls sda low", sda_drv_low, 1);
        for (int i = 0; i < 1000 && scl_drv_low; i++) step();
        gap = 0;
        while (sda_drv_low && gap < 1000) begin step(); gap++; end
        chk("R5", "sda release after scl release", gap, r + 1);
        wait_idle();
        chk("R6", "stop_seen after stop", stop_seen, 1);
    endtask

    initial begin
        repeat (3) step();
        rst = 0;
        @(negedge clk);
        chk("R1", "reset scl", scl_drv_low, 0);
        chk("R1", "reset sda", sda_drv_low, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset flags", {ack_done, stop_seen, irq, wcol}, 0);
        chk("R1", "reset txbuf", txbuf_q, 0);
        step();

        txbuf_wr = 1; txbuf_wdata = 8'h5A; step(); txbuf_wr = 0;
        chk("R7", "idle write loads", txbuf_q, 8'h5A);
        chk("R7", "idle write no wcol", wcol, 0);

        ack_timed(1'b0, 3, 0);
        ack_timed(1'b1, 0, 5);
        ack_timed(1'b0, 2, 9);
        stop_timed(2);
        stop_timed(0);

        // collision during acknowledge
        reload = 8'd4; start_ack(1'b1);
        step();
        txbuf_wr = 1; txbuf_wdata = 8'hC3; step(); txbuf_wr = 0;
        chk("R7", "wcol set on busy write", wcol, 1);
        chk("R7", "txbuf unchanged", txbuf_q, 8'h5A);
        // ignored enables while busy
        stop_go = 1; ack_go = 1; step(); stop_go = 0; ack_go = 0;
        wait_idle();
        repeat (8) step();
        chk("R8", "ignored enable left idle", busy, 0);
        chk("R8", "ignored stop left sda", sda_drv_low, 0);
        wcol_clr = 1; step(); wcol_clr = 0;
        chk("R7", "wcol cleared", wcol, 0);

        // collision during stop, and clear racing a write
        start_stop(); step();
        txbuf_wr = 1; wcol_clr = 1; txbuf_wdata = 8'h11; step(); txbuf_wr = 0; wcol_clr = 0;
        chk("R7", "write beats clear", wcol, 1);
        chk("R7", "txbuf unchanged in stop", txbuf_q, 8'h5A);
        wait_idle();

        // simultaneous requests
        reload = 8'd1; ack_bit = 0; ack_go = 1; stop_go = 1; step(); ack_go = 0; stop_go = 0;
        chk("R8", "ack wins: sda per ack_bit", sda_drv_low, 1);
        for (int i = 0; i < 1000 && !ack_done; i++) step();
        chk("R8", "busy held for queued stop", busy, 1);
        txbuf_wr = 1; txbuf_wdata = 8'h77; step(); txbuf_wr = 0;
        chk("R8", "queued stop blocks write", txbuf_q, 8'h5A);
        wait_idle();
        chk("R8", "queued stop completed", stop_seen, 1);
        chk("R8", "ack also completed", ack_done, 1);

        txbuf_wr = 1; txbuf_wdata = 8'h99; step(); txbuf_wr = 0;
        chk("R7", "later idle write loads", txbuf_q, 8'h99);
        repeat (4) step();

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule